// File: doc/BRIEF.md
# Flash Device Control-Pin and Reset Sequencer

This block sits behind the control pins of a parallel NOR-style flash device. It samples four active-low strobes on every clock: device select, output enable, write strobe, and a reset/power-down pin. From these it decides the current bus mode and whether the data pins may be driven. It also decodes write cycles into commands. These commands choose which source feeds read data (array, identifier, status or query) and start program and erase operations. A status register and a busy flag show the progress of each operation.

The reset/power-down pin is handled by a small sequencer. A low pulse shorter than a set number of clocks has no effect. A longer pulse puts the device into power-down if it is idle. If a program or erase is running, the same pulse aborts it. An abort is followed by a fixed shutdown interval. When that interval ends, the block checks the pin. If the pin has been released, the block goes back to normal operation. If the pin is still low, the block enters power-down.

Read accesses and write accesses each have their own recovery window. Both windows start when power-down is left or when shutdown ends. All analog timings are given as clock counts set by parameters. A sticky flag marks that an abort has left some data unreliable.

Top module: `flash_pin_seq`

## Requirements
- R1: `bus_mode` reports 0 (power-down) while the sequencer is shutting down or powered down. Otherwise it reports 1 (standby) when `dev_sel_n` is high, 4 (write) when `wr_strobe_n` is low and `out_en_n` is high, 3 (read) when `out_en_n` is low and `wr_strobe_n` is high, and 2 (output disabled) in any other case.
- R2: `dq_oe` is high only when four conditions all hold: the sequencer is operating, `dev_sel_n` and `out_en_n` are low, `wr_strobe_n` and `rst_pd_n` are high, and no read recovery is pending. At all other times it is low, and in particular whenever select or output enable is high.
- R3: Single-cycle commands set `rd_src`: 0xFF gives 0 (array), 0x90 gives 1 (identifier), 0x70 gives 2 (status) and 0x98 gives 3 (query). Any other single-cycle value changes nothing. After power-up and after every return from reset, `rd_src` is 0.
- R4: A write cycle is the interval in which select and write strobe are both low while output enable and reset are high. The cycle ends when either strobe rises. One clock after that, the command takes effect. For accepted commands, `lat_stb` pulses for one clock and `lat_addr`/`lat_data` show the address and data of the final cycle; for a two-cycle operation this is the second cycle.
- R5: Writing 0x40 and then any data byte starts a program. `busy` then stays high for PROG_CYC clocks. `rd_src` is 2 and `status` is 0x00 while busy. `status` becomes 0x80 when the program completes.
- R6: Writing 0x20 and then 0xD0 starts an erase, which is busy for ERASE_CYC clocks. If 0x20 is followed by any other byte, no operation starts and `rd_src` returns to 0.
- R7: A program or erase keeps running while the device is deselected. Write cycles made while `busy` is high are ignored.
- R8: A low pulse on `rst_pd_n` lasting fewer than MIN_RST consecutive clocks changes no state.
- R9: If `rst_pd_n` stays low for MIN_RST clocks while the device is idle, the block enters power-down. It leaves power-down one clock after the pin rises, with `rd_src` 0 and `status` 0x80.
- R10: After power-down or shutdown ends, reads are blocked for RD_REC clocks and writes for WR_REC clocks. `not_ready` stays high until both windows have closed. A read or write attempted inside its window raises `access_err` on the next clock and changes no state.
- R11: Holding `rst_pd_n` low for MIN_RST clocks during an operation aborts it at once. The block then spends SHUT_CYC clocks shutting down. At the end of shutdown it enters the recovery windows if the pin is high, or power-down if it is still low.
- R12: `invalid` is set by an abort. It survives power-down and is cleared only when a later program or erase completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| dev_sel_n | input | 1 | Device select strobe, active low |
| out_en_n | input | 1 | Output enable strobe, active low |
| wr_strobe_n | input | 1 | Write strobe, active low |
| rst_pd_n | input | 1 | Reset / power-down pin, active low |
| addr | input | AW | Address bus |
| wdata | input | 8 | Write data bus |
| dq_oe | output | 1 | Data pin drive enable |
| rd_src | output | 2 | Read data source select |
| bus_mode | output | 3 | Decoded bus mode |
| status | output | 8 | Status register |
| busy | output | 1 | Program or erase in progress |
| not_ready | output | 1 | Shutdown, power-down or recovery pending |
| access_err | output | 1 | Access attempted during recovery |
| invalid | output | 1 | Sticky abort-damage flag |
| lat_stb | output | 1 | Command latch pulse |
| lat_addr | output | AW | Latched command address |
| lat_data | output | 8 | Latched command data |

## Verification
Most internal state in this block can be observed at the ports within one clock. A wrong read-mode register shows up as a wrong `rd_src` on the next cycle. A sequencer state error shows up at once in `bus_mode` and `not_ready`. A recovery or shutdown counter that is off by one clock makes `dq_oe` rise one sample early or late against a clock-exact reference, so a read is held throughout each window. A lost abort stays visible long after the event: the sticky `invalid` flag stays wrong until the next completed operation.

// File: rtl/flash_pin_seq.sv
`timescale 1ns/1ps
module flash_pin_seq #(
  parameter int AW        = 16,
  parameter int MIN_RST   = 3,
  parameter int SHUT_CYC  = 6,
  parameter int RD_REC    = 5,
  parameter int WR_REC    = 8,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 60
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          dev_sel_n,
  input  logic          out_en_n,
  input  logic          wr_strobe_n,
  input  logic          rst_pd_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          dq_oe,
  output logic [1:0]    rd_src,
  output logic [2:0]    bus_mode,
  output logic [7:0]    status,
  output logic          busy,
  output logic          not_ready,
  output logic          access_err,
  output logic          invalid,
  output logic          lat_stb,
  output logic [AW-1:0] lat_addr,
  output logic [7:0]    lat_data
);
  localparam int RMAX = (RD_REC > WR_REC) ? RD_REC : WR_REC;
  localparam int OMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int RCW  = $clog2(RMAX + 1);
  localparam int OPW  = $clog2(OMAX + 1);
  localparam int SCW  = $clog2(SHUT_CYC + 1);
  localparam int LCW  = $clog2(MIN_RST + 1);

  localparam logic [1:0] ST_NORM = 2'd0, ST_SHUT = 2'd1, ST_PD = 2'd2;
  localparam logic [1:0] M_ARRAY = 2'd0, M_ID = 2'd1, M_STAT = 2'd2, M_QRY = 2'd3;
  localparam logic [1:0] S_NONE = 2'd0, S_PROG = 2'd1, S_ERASE = 2'd2;

  logic [1:0]     st, rmode, setup;
  logic [LCW-1:0] lo_cnt;
  logic [SCW-1:0] sh_cnt;
  logic [RCW-1:0] rd_wait, wr_wait;
  logic [OPW-1:0] op_cnt;
  logic           wstb_q;
  logic [AW-1:0]  a_hold;
  logic [7:0]     d_hold;

  logic norm, rst_hit, wstb, wr_edge, rd_try, known;

  assign norm    = (st == ST_NORM);
  assign rst_hit = !rst_pd_n && (lo_cnt == LCW'(MIN_RST - 1));
  assign wstb    = !dev_sel_n && !wr_strobe_n && out_en_n && rst_pd_n;
  assign wr_edge = wstb_q && !wstb;
  assign rd_try  = !dev_sel_n && !out_en_n && wr_strobe_n && rst_pd_n;
  assign known   = (d_hold == 8'hFF) || (d_hold == 8'h90) ||
                   (d_hold == 8'h70) || (d_hold == 8'h98);

  assign dq_oe     = norm && rd_try && (rd_wait == '0);
  assign busy      = (op_cnt != '0);
  assign not_ready = !norm || (rd_wait != '0) || (wr_wait != '0);
  assign rd_src    = rmode;

  always_comb begin
    if (!norm)                           bus_mode = 3'd0;
    else if (dev_sel_n)                  bus_mode = 3'd1;
    else if (!wr_strobe_n && out_en_n)   bus_mode = 3'd4;
    else if (!out_en_n && wr_strobe_n)   bus_mode = 3'd3;
    else                                 bus_mode = 3'd2;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st <= ST_NORM; rmode <= M_ARRAY; setup <= S_NONE;
      lo_cnt <= '0; sh_cnt <= '0; rd_wait <= '0; wr_wait <= '0;
      op_cnt <= '0; wstb_q <= 1'b0; a_hold <= '0; d_hold <= '0;
      status <= 8'h80; invalid <= 1'b0; access_err <= 1'b0;
      lat_stb <= 1'b0; lat_addr <= '0; lat_data <= '0;
    end else begin
      lo_cnt     <= rst_pd_n ? '0 : ((lo_cnt == LCW'(MIN_RST)) ? lo_cnt : lo_cnt + LCW'(1));
      lat_stb    <= 1'b0;
      access_err <= 1'b0;
      case (st)
        ST_NORM: begin
          if (rst_hit) begin
            wstb_q  <= 1'b0;
            setup   <= S_NONE;
            rmode   <= M_ARRAY;
            rd_wait <= '0;
            wr_wait <= '0;
            if (op_cnt != '0) begin
              st      <= ST_SHUT;
              sh_cnt  <= SCW'(SHUT_CYC);
              op_cnt  <= '0;
              invalid <= 1'b1;
            end else begin
              st     <= ST_PD;
              status <= 8'h80;
            end
          end else begin
            wstb_q <= wstb;
            if (wstb) begin
              a_hold <= addr;
              d_hold <= wdata;
            end
            if (rd_wait != '0) rd_wait <= rd_wait - RCW'(1);
            if (wr_wait != '0) wr_wait <= wr_wait - RCW'(1);
            access_err <= (rd_try && rd_wait != '0) || (wr_edge && wr_wait != '0);
            if (op_cnt != '0) begin
              op_cnt <= op_cnt - OPW'(1);
              if (op_cnt == OPW'(1)) begin
                status  <= 8'h80;
                invalid <= 1'b0;
              end
            end else if (wr_edge && wr_wait == '0) begin
              case (setup)
                S_PROG: begin
                  setup    <= S_NONE;
                  op_cnt   <= OPW'(PROG_CYC);
                  status   <= 8'h00;
                  rmode    <= M_STAT;
                  lat_stb  <= 1'b1;
                  lat_addr <= a_hold;
                  lat_data <= d_hold;
                end
                S_ERASE: begin
                  setup <= S_NONE;
                  if (d_hold == 8'hD0) begin
                    op_cnt   <= OPW'(ERASE_CYC);
                    status   <= 8'h00;
                    rmode    <= M_STAT;
                    lat_stb  <= 1'b1;
                    lat_addr <= a_hold;
                    lat_data <= d_hold;
                  end else begin
                    rmode <= M_ARRAY;
                  end
                end
                default: begin
                  if (d_hold == 8'h40) setup <= S_PROG;
                  if (d_hold == 8'h20) setup <= S_ERASE;
                  if (known) begin
                    lat_stb  <= 1'b1;
                    lat_addr <= a_hold;
                    lat_data <= d_hold;
                  end
                  case (d_hold)
                    8'hFF:   rmode <= M_ARRAY;
                    8'h90:   rmode <= M_ID;
                    8'h70:   rmode <= M_STAT;
                    8'h98:   rmode <= M_QRY;
                    default: rmode <= rmode;
                  endcase
                end
              endcase
            end
          end
        end
        ST_SHUT: begin
          if (sh_cnt == SCW'(1)) begin
            status <= 8'h80;
            rmode  <= M_ARRAY;
            if (rst_pd_n) begin
              st      <= ST_NORM;
              rd_wait <= RCW'(RD_REC);
              wr_wait <= RCW'(WR_REC);
            end else begin
              st <= ST_PD;
            end
          end else begin
            sh_cnt <= sh_cnt - SCW'(1);
          end
        end
        default: begin
          if (rst_pd_n) begin
            st      <= ST_NORM;
            rd_wait <= RCW'(RD_REC);
            wr_wait <= RCW'(WR_REC);
          end
        end
      endcase
    end
  end

  // R2
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_PD) |-> (!dq_oe && !busy && not_ready));

  // R5
  busy_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> (rd_src == M_STAT && !status[7]));

  // R5
  done_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(busy) && norm) |-> (status == 8'h80));

  // R11
  shut_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_SHUT) |-> (invalid && !busy && !dq_oe));

  // R10
  wake_block_chk: assert property (@(posedge clk) disable iff (!por_n)
    (norm && $past(st) != ST_NORM) |-> (not_ready && !dq_oe && rd_src == M_ARRAY && status == 8'h80));

  // R10
  err_window_chk: assert property (@(posedge clk) disable iff (!por_n)
    access_err |-> $past(not_ready));

  // R12
  inv_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(invalid) |-> $past(busy));
endmodule

// File: tb/tb_flash_pin_seq.sv
`timescale 1ns/1ps
module tb_flash_pin_seq;
  localparam int AW = 16, MIN_RST = 3, SHUT_CYC = 6, RD_REC = 5, WR_REC = 8;
  localparam int PROG_CYC = 20, ERASE_CYC = 60;

  logic clk = 1'b0;
  logic por_n = 1'b0, dev_sel_n = 1'b1, out_en_n = 1'b1, wr_strobe_n = 1'b1, rst_pd_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic dq_oe, busy, not_ready, access_err, invalid, lat_stb;
  logic [1:0] rd_src;
  logic [2:0] bus_mode;
  logic [7:0] status, lat_data;
  logic [AW-1:0] lat_addr;

  int n_chk = 0, n_fail = 0;
  int run = 0, last_run = 0;

  always #4 clk = ~clk;

  flash_pin_seq #(.AW(AW), .MIN_RST(MIN_RST), .SHUT_CYC(SHUT_CYC), .RD_REC(RD_REC),
    .WR_REC(WR_REC), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut (
    .clk(clk), .por_n(por_n), .dev_sel_n(dev_sel_n), .out_en_n(out_en_n),
    .wr_strobe_n(wr_strobe_n), .rst_pd_n(rst_pd_n), .addr(addr), .wdata(wdata),
    .dq_oe(dq_oe), .rd_src(rd_src), .bus_mode(bus_mode), .status(status), .busy(busy),
    .not_ready(not_ready), .access_err(access_err), .invalid(invalid),
    .lat_stb(lat_stb), .lat_addr(lat_addr), .lat_data(lat_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // behavioural reference: phase 0 operating, 1 shutting down, 2 powered down
  int m_phase, m_low, m_shut, m_rdw, m_wrw, m_op, m_src, m_pend;
  bit m_inv, m_err, m_stb, m_wq;
  int m_stat, m_ah, m_dh, m_la, m_ld;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_phase = 0; m_low = 0; m_shut = 0; m_rdw = 0; m_wrw = 0; m_op = 0; m_src = 0;
      m_pend = 0; m_inv = 0; m_err = 0; m_stb = 0; m_wq = 0; m_stat = 'h80;
      m_ah = 0; m_dh = 0; m_la = 0; m_ld = 0;
    end else begin
      int next_low;
      bit long_low, wr_now, wr_done, rd_now, wr_ok;
      long_low = !rst_pd_n && (m_low + 1 >= MIN_RST);
      next_low = rst_pd_n ? 0 : ((m_low < MIN_RST) ? m_low + 1 : m_low);
      m_stb = 0; m_err = 0;
      if (m_phase == 0 && long_low) begin
        m_wq = 0; m_pend = 0; m_src = 0; m_rdw = 0; m_wrw = 0;
        if (m_op > 0) begin m_phase = 1; m_shut = SHUT_CYC; m_op = 0; m_inv = 1; end
        else begin m_phase = 2; m_stat = 'h80; end
      end else if (m_phase == 0) begin
        wr_now  = !dev_sel_n && !wr_strobe_n && out_en_n && rst_pd_n;
        rd_now  = !dev_sel_n && !out_en_n && wr_strobe_n && rst_pd_n;
        wr_done = m_wq && !wr_now;
        wr_ok   = wr_done && m_wrw == 0;
        m_err   = (rd_now && m_rdw > 0) || (wr_done && m_wrw > 0);
        if (m_rdw > 0) m_rdw--;
        if (m_wrw > 0) m_wrw--;
        if (m_op > 0) begin
          if (m_op == 1) begin m_stat = 'h80; m_inv = 0; end
          m_op--;
        end else if (wr_ok) begin
          if (m_pend == 1 || (m_pend == 2 && m_dh == 'hD0)) begin
            m_op = (m_pend == 1) ? PROG_CYC : ERASE_CYC;
            m_stat = 0; m_src = 2; m_stb = 1; m_la = m_ah; m_ld = m_dh; m_pend = 0;
          end else if (m_pend == 2) begin
            m_pend = 0; m_src = 0;
          end else begin
            if (m_dh == 'h40) m_pend = 1;
            if (m_dh == 'h20) m_pend = 2;
            if (m_dh == 'hFF || m_dh == 'h90 || m_dh == 'h70 || m_dh == 'h98) begin
              m_src = (m_dh == 'hFF) ? 0 : (m_dh == 'h90) ? 1 : (m_dh == 'h70) ? 2 : 3;
              m_stb = 1; m_la = m_ah; m_ld = m_dh;
            end
          end
        end
        if (wr_now) begin m_ah = addr; m_dh = wdata; end
        m_wq = wr_now;
      end else if (m_phase == 1) begin
        if (m_shut == 1) begin
          m_stat = 'h80; m_src = 0;
          if (rst_pd_n) begin m_phase = 0; m_rdw = RD_REC; m_wrw = WR_REC; end
          else m_phase = 2;
        end else m_shut--;
      end else if (rst_pd_n) begin
        m_phase = 0; m_rdw = RD_REC; m_wrw = WR_REC;
      end
      m_low = next_low;
    end
  end

  always @(negedge clk) begin
    if (por_n) begin
      int e_bm;
      bit e_dq;
      if (m_phase != 0) e_bm = 0;
      else if (dev_sel_n) e_bm = 1;
      else if (!wr_strobe_n && out_en_n) e_bm = 4;
      else if (!out_en_n && wr_strobe_n) e_bm = 3;
      else e_bm = 2;
      e_dq = (m_phase == 0) && !dev_sel_n && !out_en_n && wr_strobe_n && rst_pd_n && m_rdw == 0;
      check("R1 bus_mode", 32'(bus_mode), 32'(e_bm));
      check("R2 dq_oe", 32'(dq_oe), 32'(e_dq));
      check("R3 rd_src", 32'(rd_src), 32'(m_src));
      check("R4 lat_stb", 32'(lat_stb), 32'(m_stb));
      check("R4 lat_addr", 32'(lat_addr), 32'(m_la));
      check("R4 lat_data", 32'(lat_data), 32'(m_ld));
      check("R5 busy", 32'(busy), 32'(m_op > 0));
      check("R5 status", 32'(status), 32'(m_stat));
      check("R10 not_ready", 32'(not_ready), 32'((m_phase != 0) || m_rdw > 0 || m_wrw > 0));
      check("R10 access_err", 32'(access_err), 32'(m_err));
      check("R12 invalid", 32'(invalid), 32'(m_inv));
      if (busy) run++;
      else if (run > 0) begin last_run = run; run = 0; end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr_cyc(input logic [AW-1:0] a, input logic [7:0] d, input bit sel_first);
    tick(1);
    dev_sel_n = 1'b0; wr_strobe_n = 1'b0; out_en_n = 1'b1; addr = a; wdata = d;
    tick(2);
    if (sel_first) dev_sel_n = 1'b1; else wr_strobe_n = 1'b1;
    tick(1);
    dev_sel_n = 1'b1; wr_strobe_n = 1'b1;
    tick(1);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(4);
    por_n = 1'b1;
    tick(1);
    @(negedge clk);
    check("R3 reset rd_src", 32'(rd_src), 0);
    check("R9 reset status", 32'(status), 'h80);
    check("R1 reset standby", 32'(bus_mode), 1);
    tick(1);
    dev_sel_n = 0; out_en_n = 0;
    @(negedge clk);
    check("R2 read drive", 32'(dq_oe), 1);
    check("R1 read mode", 32'(bus_mode), 3);
    tick(1); out_en_n = 1;
    @(negedge clk);
    check("R2 output disabled", 32'(dq_oe), 0);
    check("R1 outdis mode", 32'(bus_mode), 2);
    tick(1); dev_sel_n = 1;

    wr_cyc(16'h0011, 8'h90, 0);
    check("R3 identifier", 32'(rd_src), 1);
    check("R4 latched data", 32'(lat_data), 'h90);
    wr_cyc(16'h0022, 8'h98, 0);
    check("R3 query", 32'(rd_src), 3);
    wr_cyc(16'h0033, 8'h70, 1);
    check("R4 select-edge latch", 32'(lat_addr), 'h0033);
    check("R3 status mode", 32'(rd_src), 2);
    wr_cyc(16'h0044, 8'h12, 0);
    check("R3 unknown ignored", 32'(rd_src), 2);
    check("R3 unknown no latch", 32'(lat_data), 'h70);
    wr_cyc(16'h0055, 8'hFF, 0);
    check("R3 array", 32'(rd_src), 0);

    wr_cyc(16'h0100, 8'h40, 0);
    wr_cyc(16'h0222, 8'hA5, 0);
    check("R4 second cycle addr", 32'(lat_addr), 'h0222);
    check("R5 busy", 32'(busy), 1);
    check("R5 status busy", 32'(status), 0);
    wr_cyc(16'h0000, 8'hFF, 0);
    check("R7 write while busy ignored", 32'(rd_src), 2);
    tick(3);
    check("R7 runs in standby", 32'(busy), 1);
    tick(20);
    check("R5 program length", 32'(last_run), PROG_CYC);
    check("R5 ready status", 32'(status), 'h80);

    wr_cyc(16'h0300, 8'h20, 0);
    wr_cyc(16'h0300, 8'hD0, 0);
    check("R6 erase busy", 32'(busy), 1);
    tick(64);
    check("R6 erase length", 32'(last_run), ERASE_CYC);
    wr_cyc(16'h0000, 8'h90, 0);
    wr_cyc(16'h0400, 8'h20, 0);
    wr_cyc(16'h0400, 8'h33, 0);
    check("R6 bad confirm no op", 32'(busy), 0);
    check("R6 bad confirm array", 32'(rd_src), 0);

    dev_sel_n = 0; out_en_n = 0;
    rst_pd_n = 0;
    tick(MIN_RST - 1);
    rst_pd_n = 1;
    @(negedge clk);
    check("R8 short pulse ignored", 32'(bus_mode), 3);
    check("R8 read still allowed", 32'(dq_oe), 1);
    tick(1);
    dev_sel_n = 1; out_en_n = 1;

    rst_pd_n = 0;
    tick(6);
    check("R9 power-down", 32'(bus_mode), 0);
    rst_pd_n = 1;
    dev_sel_n = 0; out_en_n = 0;
    tick(2);
    @(negedge clk);
    check("R10 read blocked", 32'(dq_oe), 0);
    check("R10 read error", 32'(access_err), 1);
    tick(1); dev_sel_n = 1; out_en_n = 1;
    wr_cyc(16'h0000, 8'h90, 0);
    check("R10 write blocked", 32'(rd_src), 0);
    tick(10);
    wr_cyc(16'h0000, 8'h90, 0);
    check("R10 write after window", 32'(rd_src), 1);

    wr_cyc(16'h0500, 8'h40, 0);
    wr_cyc(16'h0501, 8'h11, 0);
    rst_pd_n = 0;
    tick(4);
    rst_pd_n = 1;
    check("R11 abort stops op", 32'(busy), 0);
    check("R11 shutdown mode", 32'(bus_mode), 0);
    check("R12 invalid set", 32'(invalid), 1);
    dev_sel_n = 0; out_en_n = 0;
    tick(9);
    @(negedge clk);
    check("R11 recovery from shutdown end", 32'(dq_oe), 0);
    check("R11 array after abort", 32'(rd_src), 0);
    tick(1);
    @(negedge clk);
    check("R11 read after recovery", 32'(dq_oe), 1);
    tick(1); dev_sel_n = 1; out_en_n = 1;

    wr_cyc(16'h0600, 8'h40, 0);
    wr_cyc(16'h0601, 8'h22, 0);
    rst_pd_n = 0;
    tick(12);
    check("R11 held low enters power-down", 32'(bus_mode), 0);
    check("R11 held low not ready", 32'(not_ready), 1);
    rst_pd_n = 1;
    tick(12);
    check("R12 invalid survives", 32'(invalid), 1);
    wr_cyc(16'h0700, 8'h40, 0);
    wr_cyc(16'h0701, 8'h33, 0);
    check("R12 invalid during op", 32'(invalid), 1);
    tick(22);
    check("R12 cleared by completion", 32'(invalid), 0);
    tick(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule